// File: doc/BRIEF.md
# Buffered SPI Master Transmitter

This block is the transmit side of an SPI master with a one-byte queue. A host drops a byte into a holding register with a single-cycle write strobe and polls `tx_empty` to learn when the next byte may be written. The byte waits in the holding register until the shift engine is free. It then moves into the shift register and goes out MSB first on `mosi`, while `miso` is shifted into a receive register.

The serial clock comes from a prescaler that counts without stopping from reset. It divides the system clock by 2, 8, 32 or 128. A transfer may only begin where a prescaler period begins, so the time from a write to the first activity varies between one cycle and one full SCK period. When a second byte is already queued as the first one finishes, it starts on the very next SCK period with no idle gap. Clock polarity and clock phase are both selectable.

The shift engine is a two-state machine. **ST_IDLE** holds SCK at its idle level. **ST_SHIFT** runs the sixteen half-periods of one byte. The transitions are:
- **launch** (ST_IDLE to ST_SHIFT): a byte is queued and the prescaler reaches the end of a period.
- **chain** (ST_SHIFT to ST_SHIFT): the last half-period of a byte ends while another byte is queued.
- **drain** (ST_SHIFT to ST_IDLE): the last half-period ends with nothing queued.

Top module: `spi_tx_master`

## Requirements
- R1: `cfg_div` selects the SCK period as 2, 8, 32 or 128 system clocks for the codes 0, 1, 2 and 3 respectively. Successive leading SCK edges are exactly that many cycles apart.
- R2: The prescaler is never restarted by a write. `busy` rises between 1 and ratio cycles after the clock edge that accepts the write, and the exact delay depends on when the write lands.
- R3: The holding register is separate from the shift register. `tx_empty` goes high again when the queued byte moves into the shifter, while the transfer is still running (`busy` high).
- R4: A byte queued before the current byte ends is sent in the following SCK period. `busy` does not drop between the bytes, and leading-edge spacing stays equal to the ratio across the byte boundary.
- R5: While `busy` is low, `sck` equals `cfg_cpol`: idle low for 0 and idle high for 1.
- R6: `tx_empty` is 1 after reset and is 0 in the cycle after an accepted write.
- R7: Bits leave on `mosi` MSB first. With `cfg_cpha`=0, the MSB is on `mosi` half a period before the first SCK edge; data is sampled on leading edges and changes on trailing edges. With `cfg_cpha`=1, data changes on leading edges and is sampled on trailing edges. `mosi` changes during a transfer only together with an SCK edge.
- R8: A write while `tx_empty` is 0 is dropped: the byte is never sent. The write sets `wcol`, which stays set until a `wcol_clr` pulse.
- R9: `miso` is captured on the sampling edge, the one opposite to the `mosi` change. After the eighth sample, `rx_data` holds the byte, first bit in bit 7, and `rx_full` is set. `rx_full` holds until an `rx_ack` pulse.
- R10: `busy` is high for exactly 8 SCK periods per byte, starting with the first period of a byte and ending with the last period of the final queued byte.
- R11: During and right after reset: `tx_empty`=1, `busy`=0, `wcol`=0, `rx_full`=0, `sck`=`cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_div | input | 2 | SCK ratio select: 0=/2, 1=/8, 2=/32, 3=/128 |
| wr_stb | input | 1 | One-cycle write of `wr_data` to the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| wcol_clr | input | 1 | Clears the write-collision flag |
| rx_ack | input | 1 | Clears the receive-full flag |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| tx_empty | output | 1 | Holding register can take a byte |
| busy | output | 1 | A byte is being shifted |
| wcol | output | 1 | Sticky write-collision flag |
| rx_full | output | 1 | A received byte waits in `rx_data` |
| rx_data | output | DATA_W | Last received byte |

## Verification
The bench builds the block with its defaults: DATA_W=8 and a 7-bit prescaler. Every divider code is therefore reachable, including /128. The shortest ratio, /2, makes each half-period a single cycle, so MISO set-up and MOSI changes are tested with no slack. The longest, /128, gives a start delay of up to 128 cycles. A /32 run with three queued writes keeps the holding register full long enough to force a write collision and to watch a chained byte boundary. A loop of /8 writes at shifted offsets shows that the start delay varies with the prescaler phase.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

    // Largest divide ratio is 2**SCK_MAX_LG system clocks.
    localparam int SCK_MAX_LG = 7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shift_state_e;

endpackage

// File: rtl/spi_tx_prescaler.sv
module spi_tx_prescaler #(
    parameter int PRE_W = spi_tx_pkg::SCK_MAX_LG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    output logic       half_tick,
    output logic       period_end
);

    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] cnt_q;
    logic [2:0]       ratio_lg;
    logic [PRE_W-1:0] per_mask;
    logic [PRE_W-1:0] half_mask;

    // Ratio is 2**(2*sel+1): 2, 8, 32, 128.
    assign ratio_lg  = {div_sel, 1'b1};
    assign per_mask  = (ONE << ratio_lg) - ONE;
    assign half_mask = per_mask >> 1;

    // Free-running count; no write ever restarts it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    always_comb begin
        half_tick  = ((cnt_q & half_mask) == half_mask);
        period_end = ((cnt_q & per_mask) == per_mask);
    end

endmodule

// File: rtl/spi_tx_holdbuf.sv
module spi_tx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              wcol_clr,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              wcol
);

    logic accept;
    logic collide;

    assign accept  = wr_stb && !hold_full;
    assign collide = wr_stb && hold_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (accept) begin
                hold_data <= wr_data;
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end

    // A collision wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcol <= 1'b0;
        end else if (collide) begin
            wcol <= 1'b1;
        end else if (wcol_clr) begin
            wcol <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_tx_engine.sv
module spi_tx_engine
    import spi_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha,
    input  logic              half_tick,
    input  logic              period_end,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              miso,
    input  logic              rx_ack,
    output logic              take,
    output logic              sck_act,
    output logic              mosi,
    output logic              busy,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_data
);

    localparam int               HALVES  = 2 * DATA_W;
    localparam int               HC_W    = $clog2(HALVES);
    localparam logic [HC_W-1:0]  LAST_H  = HC_W'(HALVES - 1);
    localparam logic [HC_W-1:0]  LAST_S  = HC_W'(HALVES - 2);

    shift_state_e      state_q, state_d;
    logic [HC_W-1:0]   hcnt_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              at_last;
    logic              launch;
    logic              chain;
    logic              step;
    logic              sample_ev;
    logic              shift_ev;
    logic              toggle_ev;

    assign at_last   = (hcnt_q == LAST_H);
    assign step      = (state_q == ST_SHIFT) && half_tick;
    assign launch    = (state_q == ST_IDLE) && hold_full && period_end;
    assign chain     = step && at_last && hold_full;
    assign take      = launch || chain;
    // Even half-periods end on a sampling edge, odd ones on a shifting edge.
    assign sample_ev = step && !hcnt_q[0];
    assign shift_ev  = step && hcnt_q[0] && !at_last;
    // With cpha=1 the leading edge comes at launch, so the final half-period has no edge.
    assign toggle_ev = step && (!cpha || !at_last);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (step && at_last && !hold_full) state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transmit datapath and SCK phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q  <= '0;
            tx_sh_q <= '0;
            sck_act <= 1'b0;
        end else if (take) begin
            hcnt_q  <= '0;
            tx_sh_q <= hold_data;
            sck_act <= cpha;
        end else if (step) begin
            hcnt_q <= hcnt_q + HC_W'(1);
            if (toggle_ev) sck_act <= ~sck_act;
            if (shift_ev)  tx_sh_q <= tx_sh_q << 1;
        end
    end

    // Receive datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh_q <= '0;
            rx_data <= '0;
            rx_full <= 1'b0;
        end else begin
            if (sample_ev) rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
            if (sample_ev && hcnt_q == LAST_S) begin
                rx_data <= {rx_sh_q[DATA_W-2:0], miso};
                rx_full <= 1'b1;
            end else if (rx_ack) begin
                rx_full <= 1'b0;
            end
        end
    end

    // Outputs.
    always_comb begin
        mosi = tx_sh_q[DATA_W-1];
        busy = (state_q == ST_SHIFT);
    end

endmodule

// File: rtl/spi_tx_master.sv
module spi_tx_master #(
    parameter int DATA_W = 8,
    parameter int PRE_W  = spi_tx_pkg::SCK_MAX_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [1:0]        cfg_div,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wcol_clr,
    input  logic              rx_ack,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              tx_empty,
    output logic              busy,
    output logic              wcol,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_data
);

    logic              half_tick;
    logic              period_end;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sck_act;

    spi_tx_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_sel    (cfg_div),
        .half_tick  (half_tick),
        .period_end (period_end)
    );

    spi_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .take      (take),
        .wcol_clr  (wcol_clr),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .wcol      (wcol)
    );

    spi_tx_engine #(.DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpha       (cfg_cpha),
        .half_tick  (half_tick),
        .period_end (period_end),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .miso       (miso),
        .rx_ack     (rx_ack),
        .take       (take),
        .sck_act    (sck_act),
        .mosi       (mosi),
        .busy       (busy),
        .rx_full    (rx_full),
        .rx_data    (rx_data)
    );

    assign sck      = cfg_cpol ^ sck_act;
    assign tx_empty = !hold_full;

endmodule

// File: rtl/spi_tx_master_chk.sv
module spi_tx_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cpol,
    input logic wr_stb,
    input logic wcol_clr,
    input logic rx_ack,
    input logic sck,
    input logic mosi,
    input logic tx_empty,
    input logic busy,
    input logic wcol,
    input logic rx_full
);

    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cfg_cpol);

    a_r6_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && tx_empty |=> !tx_empty);

    a_r8_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && !tx_empty |=> wcol);

    a_r8_wcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wcol && !wcol_clr |=> wcol);

    a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !rx_ack |=> rx_full);

    a_r7_mosi_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$stable(mosi) |-> !$stable(sck));

    a_r10_start_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !$past(busy) |-> $past(!tx_empty));

endmodule

bind spi_tx_master spi_tx_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cpol (cfg_cpol),
    .wr_stb   (wr_stb),
    .wcol_clr (wcol_clr),
    .rx_ack   (rx_ack),
    .sck      (sck),
    .mosi     (mosi),
    .tx_empty (tx_empty),
    .busy     (busy),
    .wcol     (wcol),
    .rx_full  (rx_full)
);

// File: tb/sim_spi_tx_master.sv
module sim_spi_tx_master;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_cpol, cfg_cpha;
    logic [1:0] cfg_div;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic       wcol_clr, rx_ack, miso;
    logic       sck, mosi, tx_empty, busy, wcol, rx_full;
    logic [7:0] rx_data;

    always #5 clk = ~clk;

    spi_tx_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .wr_stb(wr_stb), .wr_data(wr_data),
        .wcol_clr(wcol_clr), .rx_ack(rx_ack), .miso(miso), .sck(sck),
        .mosi(mosi), .tx_empty(tx_empty), .busy(busy), .wcol(wcol),
        .rx_full(rx_full), .rx_data(rx_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // Slave model: watches SCK, captures MOSI, drives MISO.
    logic       t_pol, t_pha, prev_sck, prev_busy, is_lead;
    int         bitn, rise_cnt, rise_cyc, busy_cyc, last_lead, min_sp, max_sp, sp;
    bit         have_lead;
    logic [7:0] cap_sh, out_byte;
    logic [7:0] cap_q[$];
    logic [7:0] miso_q[$];

    function automatic logic [7:0] pop_miso();
        if (miso_q.size() > 0) return miso_q.pop_front();
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                rise_cnt++;
                rise_cyc = cyc;
            end
            if (busy) busy_cyc++;
            prev_busy = busy;
            if (sck !== prev_sck) begin
                is_lead = (prev_sck == t_pol);
                if (is_lead) begin
                    if (have_lead) begin
                        sp = cyc - last_lead;
                        if (sp < min_sp) min_sp = sp;
                        if (sp > max_sp) max_sp = sp;
                    end
                    have_lead = 1'b1;
                    last_lead = cyc;
                end
                if (is_lead != t_pha) begin
                    cap_sh = {cap_sh[6:0], mosi};
                    bitn++;
                    if (bitn == 8) begin
                        cap_q.push_back(cap_sh);
                        bitn = 0;
                    end
                end else if (t_pha) begin
                    if (bitn == 0) out_byte = pop_miso();
                    miso = out_byte[7-bitn];
                end else begin
                    if (bitn == 0) begin
                        out_byte = pop_miso();
                        miso = out_byte[7];
                    end else begin
                        miso = out_byte[7-bitn];
                    end
                end
            end
            prev_sck = sck;
        end
    end

    task automatic configure(input logic pol, input logic pha, input logic [1:0] dv);
        @(posedge clk);
        #1;
        cfg_cpol = pol;
        cfg_cpha = pha;
        cfg_div  = dv;
        t_pol    = pol;
        t_pha    = pha;
        #1;
        prev_sck  = sck;
        prev_busy = busy;
        bitn      = 0;
        rise_cnt  = 0;
        busy_cyc  = 0;
        have_lead = 1'b0;
        min_sp    = 1 << 30;
        max_sp    = 0;
        cap_q.delete();
        if (!pha) begin
            out_byte = pop_miso();
            miso = out_byte[7];
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output int acc);
        @(posedge clk);
        #1;
        wr_stb  = 1'b1;
        wr_data = b;
        @(posedge clk);
        #1;
        acc    = cyc;
        wr_stb = 1'b0;
    endtask

    task automatic wait_done();
        while (rise_cnt == 0 || busy || !tx_empty) @(negedge clk);
    endtask

    task automatic pulse_rx_ack();
        @(posedge clk);
        #1 rx_ack = 1'b1;
        @(posedge clk);
        #1 rx_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 2'd0;
        wr_stb = 1'b0; wr_data = 8'h00; wcol_clr = 1'b0; rx_ack = 1'b0; miso = 1'b0;
        t_pol = 1'b0; t_pha = 1'b0; prev_sck = 1'b0; prev_busy = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "tx_empty in reset", int'(tx_empty), 1);
        chk("R11", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "wcol after reset", int'(wcol), 0);
        chk("R11", "rx_full after reset", int'(rx_full), 0);
        chk("R11", "sck idle after reset", int'(sck), 0);
        chk("R6", "tx_empty after reset", int'(tx_empty), 1);
    endtask

    task automatic t_single(input logic pol, input logic pha, input logic [1:0] dv,
                            input logic [7:0] txb, input logic [7:0] rxb);
        int ratio, acc;
        ratio = 2 << (2 * dv);
        miso_q.push_back(rxb);
        configure(pol, pha, dv);
        chk("R5", "idle sck before write", int'(sck), int'(pol));
        wr_byte(txb, acc);
        chk("R6", "tx_empty after write", int'(tx_empty), busy ? 1 : 0);
        wait_done();
        chk_rng("R2", "write to busy delay", rise_cyc - acc, 1, ratio);
        chk("R1", "min leading-edge spacing", min_sp, ratio);
        chk("R1", "max leading-edge spacing", max_sp, ratio);
        chk("R10", "busy cycles one byte", busy_cyc, 8 * ratio);
        chk("R7", "bytes seen by slave", cap_q.size(), 1);
        if (cap_q.size() > 0) chk("R7", "mosi byte", int'(cap_q[0]), int'(txb));
        chk("R9", "rx_full after byte", int'(rx_full), 1);
        chk("R9", "rx_data", int'(rx_data), int'(rxb));
        chk("R5", "sck idle after byte", int'(sck), int'(pol));
        chk("R3", "tx_empty after byte", int'(tx_empty), 1);
        repeat (3) @(negedge clk);
        chk("R9", "rx_full held without ack", int'(rx_full), 1);
        pulse_rx_ack();
        @(negedge clk);
        chk("R9", "rx_full after ack", int'(rx_full), 0);
    endtask

    task automatic t_back2back();
        int ratio, acc, guard;
        ratio = 32;
        miso_q.push_back(8'h11);
        miso_q.push_back(8'h22);
        miso_q.push_back(8'h3C);
        configure(1'b0, 1'b1, 2'd2);
        wr_byte(8'hA5, acc);
        chk("R6", "tx_empty right after write", int'(tx_empty), 0);
        guard = 0;
        while (!tx_empty && guard < 1000) begin @(negedge clk); guard++; end
        chk("R3", "busy when holding drained", int'(busy), 1);
        wr_byte(8'h5A, acc);
        guard = 0;
        while (!tx_empty && guard < 1000) begin @(negedge clk); guard++; end
        wr_byte(8'hC3, acc);
        wr_byte(8'hFF, acc);
        @(negedge clk);
        chk("R8", "wcol after write while full", int'(wcol), 1);
        wait_done();
        chk("R4", "busy rises once for three bytes", rise_cnt, 1);
        chk("R10", "busy cycles three bytes", busy_cyc, 24 * ratio);
        chk("R4", "min spacing across bytes", min_sp, ratio);
        chk("R4", "max spacing across bytes", max_sp, ratio);
        chk("R8", "bytes sent (dropped write absent)", cap_q.size(), 3);
        if (cap_q.size() == 3) begin
            chk("R7", "byte 1", int'(cap_q[0]), 8'hA5);
            chk("R4", "byte 2", int'(cap_q[1]), 8'h5A);
            chk("R4", "byte 3", int'(cap_q[2]), 8'hC3);
        end
        chk("R9", "rx_data after chain", int'(rx_data), 8'h3C);
        chk("R8", "wcol still set", int'(wcol), 1);
        @(posedge clk);
        #1 wcol_clr = 1'b1;
        @(posedge clk);
        #1 wcol_clr = 1'b0;
        @(negedge clk);
        chk("R8", "wcol after clear", int'(wcol), 0);
        pulse_rx_ack();
    endtask

    task automatic t_delay_spread();
        int acc, d;
        bit [15:0] seen;
        int distinct;
        seen = '0;
        for (int i = 0; i < 8; i++) begin
            configure(1'b0, 1'b0, 2'd1);
            repeat (i) @(posedge clk);
            wr_byte(8'h80 | 8'(i), acc);
            wait_done();
            d = rise_cyc - acc;
            chk_rng("R2", "delay at /8", d, 1, 8);
            if (d >= 0 && d < 16) seen[d] = 1'b1;
            if (cap_q.size() > 0) chk("R7", "byte at /8", int'(cap_q[0]), int'(8'h80 | 8'(i)));
            pulse_rx_ack();
        end
        distinct = $countones(seen);
        chk_rng("R2", "distinct start delays", distinct, 2, 8);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single(1'b0, 1'b0, 2'd0, 8'hB4, 8'h6D);
        t_single(1'b0, 1'b1, 2'd1, 8'h3E, 8'hC1);
        t_single(1'b1, 1'b0, 2'd2, 8'h81, 8'h5A);
        t_single(1'b1, 1'b1, 2'd3, 8'h4B, 8'h96);
        t_single(1'b1, 1'b1, 2'd0, 8'hF0, 8'h0F);
        t_back2back();
        t_delay_spread();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule